// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Control Register

This block is one 64-bit control word shared by up to four processors. Any processor writes it to send inter-processor interrupts, to acknowledge them, or to dismiss its periodic timer interrupt. A tick from an external timer raises the timer interrupt on every active processor. Each processor gets two level outputs: one for inter-processor interrupts and one for the timer.

Inter-processor interrupts are counted, not flagged. Every request adds one to the target's pending count and every acknowledge takes one away. The line stays high until the acknowledges match the requests. A read returns the stored word with its two lowest bits replaced by the reader's processor number. Software can therefore learn its own identity and see which timer and inter-processor status bits are set.

Top module: `ipi_timer_ctl`

## Requirements
- R1: `rd_data` is the stored word, with bits 1:0 replaced by `rd_cpu`. In the stored word, bit 4+i is processor i's timer-pending status, bit 8+i is its inter-processor status, and every other bit is zero.
- R2: A write with bit 4+i set clears processor i's timer interrupt and its status bit on the next cycle. If that interrupt is not pending, nothing changes.
- R3: A write with bit 12+i set adds one to processor i's pending count and sets status bit 8+i. `ipi_irq[i]` rises only when the count leaves zero.
- R4: A write with bit 8+i set removes one from a non-zero count of processor i and clears status bit 8+i. `ipi_irq[i]` falls when the count reaches zero.
- R5: An acknowledge to a processor whose count is zero leaves its count and its line unchanged.
- R6: A `tick` pulse sets the timer interrupt and status bit 4+i of every active processor. A processor whose timer interrupt is already pending stays as it is.
- R7: A write whose only supported bit is 28 is accepted. It changes no state and raises no error.
- R8: A write with none of bits 4..15 or 28 set pulses `wr_err` for one cycle and changes no state.
- R9: Within one write, timer clears act first, then requests, then acknowledges. A `tick` in the same cycle acts after the write's timer clear.
- R10: Pending counts saturate at 2^CNT_W-1. A request to a saturated count leaves it unchanged and pulses `ipi_ovf` for one cycle.
- R11: Field bits that belong to processors at or above NCPU have no effect.
- R12: After reset, all counts, lines, status bits, `wr_err` and `ipi_ovf` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 64 | Write data: timer clears 7:4, acknowledges 11:8, requests 15:12, no-op 28 |
| tick | input | 1 | Periodic timer event |
| rd_cpu | input | 2 | Processor number of the reader |
| rd_data | output | 64 | Read data |
| ipi_irq | output | NCPU | Inter-processor interrupt line per processor |
| tmr_irq | output | NCPU | Timer interrupt line per processor |
| wr_err | output | 1 | One-cycle pulse after an illegal write |
| ipi_ovf | output | 1 | One-cycle pulse after a request to a saturated count |

## Verification
A wrong pending count usually stays hidden while requests arrive. It shows up when the acknowledges come: the line falls one acknowledge too early or stays high one acknowledge too long. The bench therefore drains every count to zero and compares the lines on every clock. A wrong timer or status bit appears on `rd_data` and on `tmr_irq` in the cycle after the write or tick that caused it. Wrong field ordering inside one write shows up as a line or status bit that differs from the model in that same next cycle.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

    localparam int MAX_CPU  = 4;
    localparam int ID_W     = 2;
    localparam int REG_W    = 64;
    localparam int TCLR_LSB = 4;
    localparam int ACK_LSB  = 8;
    localparam int REQ_LSB  = 12;
    localparam int NOP_BIT  = 28;

    localparam logic [REG_W-1:0] LEGAL_MASK = 64'h0000_0000_1000_FFF0;

    // per-processor command decoded from one register write
    typedef struct packed {
        logic tclr;
        logic req;
        logic ack;
    } cpu_cmd_t;

    function automatic logic write_is_legal(input logic [REG_W-1:0] d);
        return |(d & LEGAL_MASK);
    endfunction

    function automatic cpu_cmd_t field_for(input logic [REG_W-1:0] d, input int idx);
        cpu_cmd_t c;
        c.tclr = d[TCLR_LSB + idx];
        c.req  = d[REQ_LSB + idx];
        c.ack  = d[ACK_LSB + idx];
        return c;
    endfunction

endpackage

// File: rtl/ipt_wr_decode.sv
module ipt_wr_decode
    import ipt_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic                  wr_en,
    input  logic [REG_W-1:0]      wr_data,
    output cpu_cmd_t [NCPU-1:0]   cmd,
    output logic                  bad
);

    // only fields of present processors are decoded
    for (genvar i = 0; i < NCPU; i++) begin : g_fld
        assign cmd[i] = wr_en ? field_for(wr_data, i) : '0;
    end

    assign bad = wr_en && !write_is_legal(wr_data);

endmodule

// File: rtl/ipt_cpu_slice.sv
module ipt_cpu_slice
    import ipt_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  cpu_cmd_t cmd,
    input  logic     tick,
    output logic     ipi_irq,
    output logic     tmr_irq,
    output logic     ipi_flag,
    output logic     sat_hit
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q, cnt_mid, cnt_n;
    logic             tmr_q, tmr_n;
    logic             flag_q, flag_n;
    logic             sat_q, sat_n;

    always_comb begin
        // timer: the write's clear first, then the tick
        tmr_n = tmr_q;
        if (cmd.tclr) tmr_n = 1'b0;
        if (tick)     tmr_n = 1'b1;

        // counter: requests first, then acknowledges
        sat_n   = cmd.req && (cnt_q == CNT_MAX);
        cnt_mid = (cmd.req && !sat_n) ? cnt_q + 1'b1 : cnt_q;
        cnt_n   = (cmd.ack && cnt_mid != '0) ? cnt_mid - 1'b1 : cnt_mid;

        flag_n = flag_q;
        if (cmd.req) flag_n = 1'b1;
        if (cmd.ack) flag_n = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            tmr_q  <= 1'b0;
            flag_q <= 1'b0;
            sat_q  <= 1'b0;
        end else begin
            cnt_q  <= cnt_n;
            tmr_q  <= tmr_n;
            flag_q <= flag_n;
            sat_q  <= sat_n;
        end
    end

    assign ipi_irq  = (cnt_q != '0);
    assign tmr_irq  = tmr_q;
    assign ipi_flag = flag_q;
    assign sat_hit  = sat_q;

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1 || cnt_q == $past(cnt_q) - 1'b1));

    // R3
    ipi_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ipi_irq) |-> $past(cmd.req));

    // R5
    ack_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.ack && !cmd.req && !ipi_irq) |=> !ipi_irq);

    // R6
    tick_sets_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> tmr_irq);

    // R2
    tmr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.tclr && !tick) |=> !tmr_irq);

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && cmd.req && !cmd.ack) |=> (cnt_q == CNT_MAX && sat_hit));

endmodule

// File: rtl/ipi_timer_ctl.sv
module ipi_timer_ctl
    import ipt_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [63:0]       wr_data,
    input  logic              tick,
    input  logic [1:0]        rd_cpu,
    output logic [63:0]       rd_data,
    output logic [NCPU-1:0]   ipi_irq,
    output logic [NCPU-1:0]   tmr_irq,
    output logic              wr_err,
    output logic              ipi_ovf
);

    cpu_cmd_t [NCPU-1:0] cmd;
    logic                bad;
    logic                err_q;
    logic [NCPU-1:0]     flag;
    logic [NCPU-1:0]     sat;

    ipt_wr_decode #(.NCPU(NCPU)) u_dec (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cmd     (cmd),
        .bad     (bad)
    );

    for (genvar i = 0; i < NCPU; i++) begin : g_cpu
        ipt_cpu_slice #(.CNT_W(CNT_W)) u_slice (
            .clk      (clk),
            .rst      (rst),
            .cmd      (cmd[i]),
            .tick     (tick),
            .ipi_irq  (ipi_irq[i]),
            .tmr_irq  (tmr_irq[i]),
            .ipi_flag (flag[i]),
            .sat_hit  (sat[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= bad;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NCPU; i++) begin
            rd_data[TCLR_LSB + i] = tmr_irq[i];
            rd_data[ACK_LSB + i]  = flag[i];
        end
        rd_data[ID_W-1:0] = rd_cpu;
    end

    assign wr_err  = err_q;
    assign ipi_ovf = |sat;

    // R8
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        bad |=> ($stable(ipi_irq) && $stable(flag)));

    // R1
    rd_id_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[1:0] == rd_cpu);

    initial begin
        ncpu_range_chk: assert (NCPU >= 1 && NCPU <= MAX_CPU);
    end

endmodule

// File: tb/ipi_timer_ctl_bench.sv
module ipi_timer_ctl_bench;

    localparam int N    = 3;
    localparam int CMAX = 15;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        tick = 1'b0;
    logic [1:0]  rd_cpu = 2'd2;
    logic [63:0] rd_data;
    logic [N-1:0] ipi_irq, tmr_irq;
    logic        wr_err, ipi_ovf;

    int n_tests = 0;
    int n_fail  = 0;
    int rdsel   = 0;

    // reference state
    int m_cnt [0:3];
    bit m_tmr [0:3];
    bit m_flg [0:3];
    bit m_err, m_ovf;

    always #2 clk = ~clk;

    ipi_timer_ctl #(.NCPU(N), .CNT_W(4)) u_ipi_timer_ctl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .tick(tick),
        .rd_cpu(rd_cpu), .rd_data(rd_data), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq),
        .wr_err(wr_err), .ipi_ovf(ipi_ovf)
    );

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        logic [63:0] er;
        logic [N-1:0] ei, et;
        er = '0;
        for (int i = 0; i < N; i++) begin
            er[4+i] = m_tmr[i];
            er[8+i] = m_flg[i];
            ei[i]   = (m_cnt[i] != 0);
            et[i]   = m_tmr[i];
        end
        er[1:0] = rd_cpu;
        chk(tag, "ipi_irq", 64'(ipi_irq), 64'(ei));
        chk(tag, "tmr_irq", 64'(tmr_irq), 64'(et));
        chk(tag, "wr_err", 64'(wr_err), 64'(m_err));
        chk(tag, "ipi_ovf", 64'(ipi_ovf), 64'(m_ovf));
        chk(tag, "rd_data", rd_data, er);
    endtask

    task automatic step(string tag, bit w, logic [63:0] d, bit t);
        wr_en   = w;
        wr_data = d;
        tick    = t;
        rd_cpu  = 2'(rdsel);
        rdsel   = (rdsel + 1) % 4;
        @(posedge clk);
        m_err = w && ((d & 64'h1000_FFF0) == 0);
        m_ovf = 1'b0;
        if (w) begin
            for (int i = 0; i < N; i++) begin
                if (d[4+i]) m_tmr[i] = 1'b0;
                if (d[12+i]) begin
                    if (m_cnt[i] == CMAX) m_ovf = 1'b1;
                    else m_cnt[i]++;
                    m_flg[i] = 1'b1;
                end
                if (d[8+i]) begin
                    if (m_cnt[i] > 0) m_cnt[i]--;
                    m_flg[i] = 1'b0;
                end
            end
        end
        if (t) for (int i = 0; i < N; i++) m_tmr[i] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        tick  = 1'b0;
        compare(tag);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_cnt[i] = 0; m_tmr[i] = 0; m_flg[i] = 0;
        end
        m_err = 0; m_ovf = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare("R12");

        step("R1", 1'b0, '0, 1'b0);
        step("R6", 1'b0, '0, 1'b1);
        step("R6", 1'b0, '0, 1'b1);
        step("R2", 1'b1, 64'h0000_0020, 1'b0);
        step("R2", 1'b1, 64'h0000_0020, 1'b0);
        step("R11", 1'b1, 64'h0000_8880, 1'b0);
        step("R3", 1'b1, 64'h0000_1000, 1'b0);
        step("R3", 1'b1, 64'h0000_1000, 1'b0);
        step("R4", 1'b1, 64'h0000_0100, 1'b0);
        step("R4", 1'b1, 64'h0000_0100, 1'b0);
        step("R5", 1'b1, 64'h0000_0100, 1'b0);
        step("R5", 1'b1, 64'h0000_0200, 1'b0);
        step("R7", 1'b1, 64'h1000_0000, 1'b0);
        step("R8", 1'b1, 64'h0000_0001, 1'b0);
        step("R8", 1'b1, 64'h0000_0000, 1'b0);
        step("R8", 1'b1, 64'hFFFF_0000_0001_000F, 1'b0);
        step("R9", 1'b1, 64'h0000_4400, 1'b0);
        step("R9", 1'b1, 64'h0000_2010, 1'b1);
        step("R9", 1'b1, 64'h0000_0270, 1'b0);
        step("R6", 1'b0, '0, 1'b1);
        step("R9", 1'b1, 64'h0000_3300, 1'b0);
        for (int k = 0; k < 17; k++) step("R10", 1'b1, 64'h0000_2000, 1'b0);
        step("R10", 1'b1, 64'h0000_2200, 1'b0);
        for (int k = 0; k < 16; k++) step("R4", 1'b1, 64'h0000_0200, 1'b0);
        step("R11", 1'b1, 64'h0000_8000, 1'b0);
        step("R1", 1'b0, '0, 1'b0);
        step("R1", 1'b0, '0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule